// File: doc/BRIEF.md
# CAN Node Interrupt Router

This block collects the interrupt-worthy status events of a single CAN controller node and steers each one onto one of eight shared interrupt request lines. Four event classes are recognised: a successful transmit or receive status update, a fresh bus error code report, an overflow of the node's frame counter, and any toggle of the error-warning or bus-off flags. The protocol engine, the error counters and the frame counter sit outside. Their one-cycle status pulses and level flags arrive as inputs.

Each class has an enable bit and a 3-bit line selector. Both are written through a small register write port. In each cycle, every enabled class whose event occurred is decoded onto its selected line. The result is registered, so each event cycle gives a one-cycle pulse on the output one clock later. Classes that select the same line are merged by OR. An event whose class is disabled is discarded and is not remembered.

Top module: `can_irq_router`

## Requirements
- R1: After reset, `irq_o` is all zero, all four enables are 0 and all four selectors point to line 0.
- R2: Class 0 (enable bit 0, selector at address 4) fires when `trx_ok_tx_i` or `trx_ok_rx_i` is high in a cycle. `irq_o[sel]` is then high in the following cycle.
- R3: Class 1 (enable bit 1, selector at address 5) fires when `lec_new_i` is high.
- R4: Class 2 (enable bit 2, selector at address 6) fires when `cnt_ovf_i` is high.
- R5: Class 3 (enable bit 3, selector at address 7) fires in any cycle where `err_warn_i` or `bus_off_i` differs from its value in the previous cycle. This covers both rising and falling changes. Steady flags produce nothing.
- R6: A disabled class produces no request. Its event is lost, and enabling the class later does not replay it.
- R7: Classes that fire in the same cycle and select the same line give one merged pulse on that line. Classes that select different lines pulse each of their lines.
- R8: A configuration write takes effect for events in the cycle after the write. An event in the same cycle as the write still uses the old setting.
- R9: A write to address 0 loads the enables from `cfg_wdata_i[3:0]`, with bit k for class k. A write to address 4+k loads the selector of class k from `cfg_wdata_i[2:0]`. Writes to addresses 1 to 3 change nothing.
- R10: An event present for one cycle yields an output pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| trx_ok_tx_i | input | 1 | Error-free transmit status update pulse |
| trx_ok_rx_i | input | 1 | Error-free receive status update pulse |
| lec_new_i | input | 1 | New last-error-code report pulse |
| cnt_ovf_i | input | 1 | Frame counter overflow pulse |
| err_warn_i | input | 1 | Error-warning flag level |
| bus_off_i | input | 1 | Bus-off flag level |
| irq_o | output | 8 | Interrupt request lines, one-cycle pulses |

## Verification
The bench goes after four things that are easy to get wrong: the falling edges of the warning and bus-off flags, a write that coincides with an event, several classes aimed at one line, and a class enabled right after its event was dropped. A design that detected only rising flag edges would miss the pulse when bus-off clears. A design with combinational configuration would fire on the write cycle. Merging by addition or by priority would lose or corrupt the bits of a shared line. Holding a disabled event pending would produce a late, spurious pulse. Random traffic with changing selectors is compared cycle by cycle against a bench model.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
  localparam int NUM_SRC   = 4;
  localparam int CFG_AW    = 3;
  localparam int CFG_DW    = 8;
  localparam int SRC_TRX   = 0;
  localparam int SRC_LEC   = 1;
  localparam int SRC_CNT   = 2;
  localparam int SRC_ERR   = 3;
  localparam logic [CFG_AW-1:0] ADDR_ENABLE = 3'd0;
endpackage

// File: rtl/can_irq_cfg.sv
module can_irq_cfg
  import can_irq_pkg::*;
#(
  parameter int PTR_W = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we_i,
  input  logic [CFG_AW-1:0]                addr_i,
  input  logic [CFG_DW-1:0]                wdata_i,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [NUM_SRC-1:0][PTR_W-1:0]    ptr_o
);
  logic [NUM_SRC-1:0]            en_q, en_d;
  logic [NUM_SRC-1:0][PTR_W-1:0] ptr_q, ptr_d;
  logic                          unused_wbits;

  assign unused_wbits = ^wdata_i[CFG_DW-1:NUM_SRC];

  always_comb begin
    en_d  = en_q;
    ptr_d = ptr_q;
    if (we_i) begin
      if (addr_i == ADDR_ENABLE) begin
        en_d = wdata_i[NUM_SRC-1:0];
      end else if (addr_i[CFG_AW-1]) begin
        ptr_d[addr_i[1:0]] = wdata_i[PTR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ptr_q <= '0;
    end else if (we_i) begin
      en_q  <= en_d;
      ptr_q <= ptr_d;
    end
  end

  assign en_o  = en_q;
  assign ptr_o = ptr_q;

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ptr_q));
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i != ADDR_ENABLE) |=> $stable(en_q));
endmodule

// File: rtl/can_irq_src.sv
module can_irq_src
  import can_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               tx_ok_i,
  input  logic               rx_ok_i,
  input  logic               lec_i,
  input  logic               ovf_i,
  input  logic               warn_i,
  input  logic               boff_i,
  output logic [NUM_SRC-1:0] fire_o
);
  logic warn_q, boff_q;
  logic flag_chg;
  logic [NUM_SRC-1:0] raw;

  assign flag_chg = (warn_i ^ warn_q) | (boff_i ^ boff_q);

  always_comb begin
    raw          = '0;
    raw[SRC_TRX] = tx_ok_i | rx_ok_i;
    raw[SRC_LEC] = lec_i;
    raw[SRC_CNT] = ovf_i;
    raw[SRC_ERR] = flag_chg;
  end

  assign fire_o = raw & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q <= 1'b0;
      boff_q <= 1'b0;
    end else begin
      warn_q <= warn_i;
      boff_q <= boff_i;
    end
  end

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_q == warn_i && boff_q == boff_i) |-> !fire_o[SRC_ERR]);
endmodule

// File: rtl/can_irq_route.sv
module can_irq_route
  import can_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PTR_W     = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SRC-1:0]            fire_i,
  input  logic [NUM_SRC-1:0][PTR_W-1:0] ptr_i,
  output logic [NUM_LINES-1:0]          irq_o
);
  logic [NUM_LINES-1:0] irq_d, irq_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [NUM_SRC-1:0] hit;
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
      assign hit[k] = fire_i[k] && (ptr_i[k] == PTR_W'(l));
    end
    assign irq_d[l] = |hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  assert_irq_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_q) |-> $past(|fire_i));
  assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(fire_i)) == 1) |-> ($countones(irq_q) == 1));
  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i == '0) |=> (irq_q == '0));
endmodule

// File: rtl/can_irq_router.sv
module can_irq_router
  import can_irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int PTR_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0]    cfg_wdata_i,
  input  logic                 trx_ok_tx_i,
  input  logic                 trx_ok_rx_i,
  input  logic                 lec_new_i,
  input  logic                 cnt_ovf_i,
  input  logic                 err_warn_i,
  input  logic                 bus_off_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_SRC-1:0]            en;
  logic [NUM_SRC-1:0][PTR_W-1:0] ptr;
  logic [NUM_SRC-1:0]            fire;

  can_irq_cfg #(.PTR_W(PTR_W)) cfg_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .en_o(en), .ptr_o(ptr)
  );

  can_irq_src src_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .tx_ok_i(trx_ok_tx_i),
    .rx_ok_i(trx_ok_rx_i), .lec_i(lec_new_i), .ovf_i(cnt_ovf_i),
    .warn_i(err_warn_i), .boff_i(bus_off_i), .fire_o(fire)
  );

  can_irq_route #(.NUM_LINES(NUM_LINES), .PTR_W(PTR_W)) route_i (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .ptr_i(ptr), .irq_o(irq_o)
  );

  assert_no_irq_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en == '0) |-> (irq_o == '0));
endmodule

// File: tb/can_irq_router_tb.sv
module can_irq_router_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       we;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic       tx, rx, lec, ovf, warn, boff;
  logic [7:0] irq;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0]      m_en;
  logic [3:0][2:0] m_ptr;
  logic            m_warn, m_boff;

  always #10 clk = ~clk;

  can_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .trx_ok_tx_i(tx), .trx_ok_rx_i(rx),
    .lec_new_i(lec), .cnt_ovf_i(ovf), .err_warn_i(warn),
    .bus_off_i(boff), .irq_o(irq)
  );

  function automatic logic [7:0] exp_irq(logic [3:0] en, logic [3:0][2:0] p,
      logic t, logic r, logic l, logic o, logic chg);
    logic [3:0] f;
    logic [7:0] v;
    f = {chg, o, l, t | r} & en;
    v = '0;
    for (int k = 0; k < 4; k++) if (f[k]) v[p[k]] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: irq_o=%b expected %b", req, act, expv);
    end
  endtask

  // One cycle: inputs applied after a falling edge, result checked at the next falling edge
  task automatic cyc(string req, logic w, logic [2:0] a, logic [7:0] d,
      logic t, logic r, logic l, logic o, logic wn, logic bo);
    logic [7:0] e;
    we = w; addr = a; wdata = d; tx = t; rx = r; lec = l; ovf = o;
    warn = wn; boff = bo;
    e = exp_irq(m_en, m_ptr, t, r, l, o, (wn != m_warn) || (bo != m_boff));
    m_warn = wn; m_boff = bo;
    if (w) begin
      if (a == 3'd0) m_en = d[3:0];
      else if (a[2]) m_ptr[a[1:0]] = d[2:0];
    end
    @(negedge clk);
    check(req, irq, e);
  endtask

  task automatic idle(string req);
    cyc(req, 0, 0, 0, 0, 0, 0, 0, m_warn, m_boff);
  endtask

  task automatic wr(string req, logic [2:0] a, logic [7:0] d);
    cyc(req, 1, a, d, 0, 0, 0, 0, m_warn, m_boff);
  endtask

  initial begin
    #200000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a));
    m_en = '0; m_ptr = '0; m_warn = 0; m_boff = 0;
    rst_n = 0; we = 0; addr = 0; wdata = 0;
    tx = 0; rx = 0; lec = 0; ovf = 0; warn = 0; boff = 0;
    repeat (3) @(negedge clk);
    check("R1 reset", irq, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle", irq, 8'h00);
    // R1: all selectors at line 0 after reset
    wr("R9", 3'd0, 8'h0f);
    cyc("R1 ptr0", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R1 line0", irq, 8'h01);
    idle("R10 pulse end");
    // R2 / R3 / R4 on distinct lines
    wr("R9", 3'd4, 8'd2); wr("R9", 3'd5, 8'd5);
    wr("R9", 3'd6, 8'd7); wr("R9", 3'd7, 8'd3);
    cyc("R2 rx", 0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc("R3 lec", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    cyc("R4 ovf", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R5: rise and fall of each flag
    cyc("R5 warn rise", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    idle("R5 steady");
    cyc("R5 boff rise", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R5 warn fall", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R5 boff fall", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R5 boff fall line3", irq, 8'h08);
    // R7: all fire together, separate lines then shared line
    cyc("R7 split", 0, 0, 0, 1, 1, 1, 1, 1, 0);
    check("R7 split lines", irq, 8'b1010_1100);
    wr("R7", 3'd5, 8'd2); wr("R7", 3'd6, 8'd2);
    cyc("R7 merged", 0, 0, 0, 1, 0, 1, 1, 0, 0);
    check("R7 merged line", irq, 8'b0000_1100);
    // R6: dropped event not replayed
    wr("R6", 3'd0, 8'h00);
    cyc("R6 dropped", 0, 0, 0, 1, 1, 1, 1, 1, 1);
    check("R6 silent", irq, 8'h00);
    wr("R6", 3'd0, 8'h0f);
    idle("R6 no replay");
    check("R6 no replay", irq, 8'h00);
    // R8: write and event together uses old setting
    wr("R8", 3'd0, 8'h00);
    cyc("R8 same cycle", 1, 3'd0, 8'h01, 1, 0, 0, 0, 1, 1);
    check("R8 old enable", irq, 8'h00);
    cyc("R8 next cycle", 1, 3'd4, 8'd6, 0, 1, 0, 0, 1, 1);
    check("R8 old ptr", irq, 8'h04);
    cyc("R8 new ptr", 0, 0, 0, 1, 0, 0, 0, 1, 1);
    check("R8 new ptr line", irq, 8'h40);
    // R9: addresses 1..3 ignored
    wr("R9", 3'd1, 8'hff); wr("R9", 3'd2, 8'hff); wr("R9", 3'd3, 8'hff);
    cyc("R9 ignored", 0, 0, 0, 0, 0, 1, 1, 1, 1);
    check("R9 ignored", irq, 8'h00);
    // random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      logic w;
      logic [2:0] a;
      w = ($urandom % 6) == 0;
      a = 3'($urandom);
      cyc("R7 random", w, a, 8'($urandom),
          ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 5) == 0,
          ($urandom % 5) == 0, ($urandom % 7) == 0 ? ~m_warn : m_warn,
          ($urandom % 9) == 0 ? ~m_boff : m_boff);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule